// File: doc/BRIEF.md
# I2C Master Write Controller

This block is an I2C bus master that only writes. Software loads a 7-bit target address, a byte count and a start request into a command word. The block then issues START and sends the address byte with the write direction. After each acknowledged byte it raises a transmit request, and software answers that request by loading the next data byte. When the last byte is acknowledged, or when any byte is refused, the block ends the transfer with STOP on its own. Latched NACK and STOP flags record the outcome, and software clears them by writing ones to a clear register.

The status flags follow one fixed rule. A transmit request is raised only after an acknowledge, and only while bytes remain to be sent. A refused byte therefore never produces a request, and software cannot feed data into a transfer that has already failed. While a request is pending, the block holds SCL low, which stretches the bus until the byte arrives. A divider register sets the length of a quarter of one SCL period in clock cycles. The divider keeps its value when the block is disabled.

The bus pins are open-drain: each `*_oe` output pulls its line low when it is 1. `sda_in` is the resolved SDA line. Register access uses one write strobe and an address. Read data is registered and appears one cycle after the address is presented.

Top module: `i2c_wr_master`

## Requirements
- R1: Registers are words at offsets 0 enable (bit 0), 1 command, 2 divider, 3 status, 4 clear, 5 transmit byte (bits 7:0). After reset, status reads 0x00000001 and the divider reads its reset value. Both bus lines are released.
- R2: Command word fields are address<<1 in bits 7:1, direction in bit 10 (0 = write), start in bit 13, byte count in bits 23:16 and auto-stop in bit 25. Status bits are 0 transmit empty, 1 transmit request, 4 NACK, 5 STOP and 15 busy. Once the address is acknowledged with a count above zero, status reads 0x8003.
- R3: The bus shows START (SDA falls while SCL is high), then the address byte and each data byte MSB first with SDA stable while SCL is high, and exactly one STOP (SDA rises while SCL is high).
- R4: Every acknowledged data byte that is not the last one is followed by a new transmit request, which reads as status 0x8003. Writing the transmit byte clears the request.
- R5: After the last byte is acknowledged, the block issues STOP. Status then reads 0x21, with busy clear.
- R6: A refused address byte leads straight to STOP. No data byte is requested or sent, and status reads 0x31.
- R7: A refused data byte leads to STOP with status 0x31. The transmit request is never raised after the refusal.
- R8: Writing a 1 to bit 4 or bit 5 of the clear register clears only that flag. Transmit empty is live status and is not affected, so after both flags are cleared, status reads 0x01.
- R9: While a transmit request is pending, SCL is held low.
- R10: A count of zero sends only the address byte, then STOP, and status reads 0x21.
- R11: A start request that has the direction bit set, or the auto-stop bit clear, is ignored. Busy stays clear and both lines stay released.
- R12: Clearing the enable bit aborts any transfer, releases both lines and clears all flags. The divider keeps its value when the block is re-enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word offset for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for the previous cycle's address |
| sda_in | input | 1 | Resolved SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
The assertions assume that the target changes SDA only while SCL is low. They also assume that software writes the transmit byte only while a request is pending. The bench's target model respects the first rule: it acts on SDA only after a falling SCL edge, pulling it for the acknowledge slot and releasing it at the next fall. The bench respects the second rule: it loads a byte only after it has read a status word with the request bit set. Random transfers vary the address, the count, and where the target refuses a byte. Directed cases cover a zero count, ignored start requests and an abort through disable.

// File: rtl/i2c_wr_pkg.sv
package i2c_wr_pkg;
  localparam int REG_AW = 3;
  localparam int CNT_W  = 8;

  localparam logic [REG_AW-1:0] A_ENABLE = 3'd0;
  localparam logic [REG_AW-1:0] A_CMD    = 3'd1;
  localparam logic [REG_AW-1:0] A_DIV    = 3'd2;
  localparam logic [REG_AW-1:0] A_STAT   = 3'd3;
  localparam logic [REG_AW-1:0] A_CLEAR  = 3'd4;
  localparam logic [REG_AW-1:0] A_TXB    = 3'd5;

  // command word bit positions (software encoding)
  localparam int CMD_DIR  = 10;
  localparam int CMD_GO   = 13;
  localparam int CMD_CNT  = 16;
  localparam int CMD_AUTO = 25;

  // status word bit positions
  localparam int SB_TXE  = 0;
  localparam int SB_REQ  = 1;
  localparam int SB_NACK = 4;
  localparam int SB_STOP = 5;
  localparam int SB_BUSY = 15;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_BIT,
    ST_WAIT,
    ST_STOP
  } eng_st_e;
endpackage

// File: rtl/i2c_wr_tick.sv
module i2c_wr_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             srst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  // one tick every div+1 cycles marks the end of a quarter bit
  always_ff @(posedge clk) begin
    if (srst || !run) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else if (cnt_q >= div) begin
      cnt_q <= '0;
      tick  <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      tick  <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_wr_engine.sv
module i2c_wr_engine
  import i2c_wr_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic             clk,
  input  logic             srst,
  input  logic             tick,
  input  logic             start,
  input  logic [6:0]       addr7,
  input  logic [CNT_W-1:0] count,
  input  logic             tx_valid,
  input  logic [7:0]       tx_byte,
  input  logic             sda_s,
  output logic             run,
  output logic             tx_take,
  output logic             ev_req,
  output logic             ev_nack,
  output logic             ev_stop,
  output logic             busy,
  output logic             scl_oe,
  output logic             sda_oe
);
  localparam int          SLOT_W   = $clog2(BYTE_W + 1);
  localparam logic [SLOT_W-1:0] ACK_SLOT = SLOT_W'(BYTE_W);

  eng_st_e           st_q;
  logic [1:0]        q_q;
  logic [SLOT_W-1:0] bitn_q;
  logic [7:0]        sh_q;
  logic [CNT_W-1:0]  rem_q;
  logic              scl_d, sda_d, bitph_q;

  assign run = (st_q != ST_IDLE);

  // Line levels per state and quarter. SDA is held through quarter 0 so
  // that it never moves in the same cycle as an SCL edge.
  always_comb begin
    scl_d = 1'b0;
    sda_d = 1'b0;
    unique case (st_q)
      ST_IDLE:  ;
      ST_START: begin
        sda_d = (q_q != 2'd0);
        scl_d = (q_q == 2'd3);
      end
      ST_BIT: begin
        scl_d = (q_q < 2'd2);
        if (q_q == 2'd0) sda_d = sda_oe;
        else             sda_d = (bitn_q == ACK_SLOT) ? 1'b0 : !sh_q[7];
      end
      ST_WAIT: begin
        scl_d = 1'b1;
        sda_d = sda_oe;
      end
      ST_STOP: begin
        scl_d = (q_q < 2'd2);
        sda_d = (q_q == 2'd0) ? sda_oe : (q_q != 2'd3);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (srst) begin
      st_q    <= ST_IDLE;
      q_q     <= 2'd0;
      bitn_q  <= '0;
      sh_q    <= '0;
      rem_q   <= '0;
      busy    <= 1'b0;
      tx_take <= 1'b0;
      ev_req  <= 1'b0;
      ev_nack <= 1'b0;
      ev_stop <= 1'b0;
      scl_oe  <= 1'b0;
      sda_oe  <= 1'b0;
      bitph_q <= 1'b0;
    end else begin
      tx_take <= 1'b0;
      ev_req  <= 1'b0;
      ev_nack <= 1'b0;
      ev_stop <= 1'b0;
      scl_oe  <= scl_d;
      sda_oe  <= sda_d;
      bitph_q <= (st_q == ST_BIT);
      unique case (st_q)
        ST_IDLE: begin
          if (start) begin
            st_q   <= ST_START;
            q_q    <= 2'd0;
            sh_q   <= {addr7, 1'b0};
            bitn_q <= '0;
            rem_q  <= count;
            busy   <= 1'b1;
          end
        end
        ST_START: begin
          if (tick) begin
            q_q <= q_q + 2'd1;
            if (q_q == 2'd3) st_q <= ST_BIT;
          end
        end
        ST_BIT: begin
          if (tick) begin
            q_q <= q_q + 2'd1;
            if (q_q == 2'd3) begin
              if (bitn_q != ACK_SLOT) begin
                sh_q   <= {sh_q[6:0], 1'b0};
                bitn_q <= bitn_q + 1'b1;
              end else begin
                bitn_q <= '0;
                if (sda_s) begin
                  ev_nack <= 1'b1;
                  st_q    <= ST_STOP;
                end else if (rem_q == '0) begin
                  st_q <= ST_STOP;
                end else begin
                  ev_req <= 1'b1;
                  st_q   <= ST_WAIT;
                end
              end
            end
          end
        end
        ST_WAIT: begin
          if (tick && tx_valid) begin
            tx_take <= 1'b1;
            sh_q    <= tx_byte;
            rem_q   <= rem_q - 1'b1;
            q_q     <= 2'd0;
            st_q    <= ST_BIT;
          end
        end
        ST_STOP: begin
          if (tick) begin
            q_q <= q_q + 2'd1;
            if (q_q == 2'd3) begin
              st_q    <= ST_IDLE;
              busy    <= 1'b0;
              ev_stop <= 1'b1;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  AST_SDA_STABLE_SCL_HIGH: assert property (@(posedge clk) disable iff (srst)
    (bitph_q && $past(bitph_q) && !scl_oe && $past(!scl_oe)) |-> $stable(sda_oe)); // R3
  AST_IDLE_BUS_FREE: assert property (@(posedge clk) disable iff (srst)
    (st_q == ST_IDLE && $past(st_q == ST_IDLE)) |-> (!scl_oe && !sda_oe)); // R11
  AST_EVT_EXCL: assert property (@(posedge clk) disable iff (srst)
    $onehot0({ev_req, ev_nack, tx_take})); // R7
  AST_WAIT_HOLDS_SCL: assert property (@(posedge clk) disable iff (srst)
    (st_q == ST_WAIT && $past(st_q == ST_WAIT)) |-> scl_oe); // R9
endmodule

// File: rtl/i2c_wr_regs.sv
module i2c_wr_regs
  import i2c_wr_pkg::*;
#(
  parameter int          DIV_W     = 16,
  parameter int unsigned DIV_RESET = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [REG_AW-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              srst,
  output logic              start,
  output logic [6:0]        addr7,
  output logic [CNT_W-1:0]  count,
  output logic [DIV_W-1:0]  div,
  output logic              tx_valid,
  output logic [7:0]        tx_byte,
  input  logic              tx_take,
  input  logic              ev_req,
  input  logic              ev_nack,
  input  logic              ev_stop,
  input  logic              busy
);
  logic             en_q, req_q, nack_q, stop_q, full_q;
  logic [DIV_W-1:0] div_q;
  logic [31:0]      stat, cmd_img;
  logic             wr_en, wr_cmd, wr_div, wr_clr, wr_txb, cmd_ok;
  logic             unused_wdata;

  assign unused_wdata = ^wdata;
  assign wr_en  = wr && (addr == A_ENABLE);
  assign wr_cmd = wr && (addr == A_CMD);
  assign wr_div = wr && (addr == A_DIV);
  assign wr_clr = wr && (addr == A_CLEAR);
  assign wr_txb = wr && (addr == A_TXB);
  assign cmd_ok = wdata[CMD_GO] && !wdata[CMD_DIR] && wdata[CMD_AUTO];

  // configuration survives disable; only the global reset touches it
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b0;
      div_q <= DIV_W'(DIV_RESET);
    end else begin
      if (wr_en)  en_q  <= wdata[0];
      if (wr_div) div_q <= wdata[DIV_W-1:0];
    end
  end

  assign srst     = rst || !en_q;
  assign div      = div_q;
  assign tx_valid = full_q;

  always_ff @(posedge clk) begin
    if (srst) begin
      start   <= 1'b0;
      addr7   <= '0;
      count   <= '0;
      full_q  <= 1'b0;
      tx_byte <= '0;
      req_q   <= 1'b0;
      nack_q  <= 1'b0;
      stop_q  <= 1'b0;
    end else begin
      start <= wr_cmd && cmd_ok && !busy && !start;
      if (wr_cmd && cmd_ok && !busy && !start) begin
        addr7 <= wdata[7:1];
        count <= wdata[CMD_CNT +: CNT_W];
      end
      if (wr_txb) begin
        tx_byte <= wdata[7:0];
        full_q  <= 1'b1;
      end else if (tx_take) begin
        full_q  <= 1'b0;
      end
      if (ev_req)      req_q <= 1'b1;
      else if (wr_txb) req_q <= 1'b0;
      if (ev_nack)                      nack_q <= 1'b1;
      else if (wr_clr && wdata[SB_NACK]) nack_q <= 1'b0;
      if (ev_stop)                      stop_q <= 1'b1;
      else if (wr_clr && wdata[SB_STOP]) stop_q <= 1'b0;
    end
  end

  always_comb begin
    stat          = '0;
    stat[SB_TXE]  = !full_q;
    stat[SB_REQ]  = req_q;
    stat[SB_NACK] = nack_q;
    stat[SB_STOP] = stop_q;
    stat[SB_BUSY] = busy;
    cmd_img       = '0;
    cmd_img[7:1]  = addr7;
    cmd_img[CMD_CNT +: CNT_W] = count;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      unique case (addr)
        A_ENABLE: rdata <= {31'd0, en_q};
        A_CMD:    rdata <= cmd_img;
        A_DIV:    rdata <= 32'(div_q);
        A_STAT:   rdata <= stat;
        default:  rdata <= '0;
      endcase
    end
  end

  AST_NACK_NO_REQ: assert property (@(posedge clk) disable iff (srst)
    ev_nack |=> !req_q); // R7
  AST_CLEAR_NACK: assert property (@(posedge clk) disable iff (srst)
    (wr_clr && wdata[SB_NACK] && !ev_nack) |=> !nack_q); // R8
  AST_STOP_LATCH: assert property (@(posedge clk) disable iff (srst)
    ev_stop |=> (stop_q && !busy)); // R5
  AST_LOAD_DROPS_REQ: assert property (@(posedge clk) disable iff (srst)
    (wr_txb && !ev_req) |=> !req_q); // R4
endmodule

// File: rtl/i2c_wr_master.sv
module i2c_wr_master
  import i2c_wr_pkg::*;
#(
  parameter int          DIV_W       = 16,
  parameter int unsigned DIV_RESET   = 9,
  parameter int          SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              sda_in,
  output logic              scl_oe,
  output logic              sda_oe
);
  logic [SYNC_STAGES-1:0] sda_sync_q;
  logic             srst, start, tick, run, tx_valid, tx_take;
  logic             ev_req, ev_nack, ev_stop, busy;
  logic [6:0]       addr7;
  logic [CNT_W-1:0] count;
  logic [DIV_W-1:0] div;
  logic [7:0]       tx_byte;

  always_ff @(posedge clk) begin
    if (rst) sda_sync_q <= '1;
    else     sda_sync_q <= {sda_sync_q[SYNC_STAGES-2:0], sda_in};
  end

  i2c_wr_regs #(.DIV_W(DIV_W), .DIV_RESET(DIV_RESET)) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .srst(srst), .start(start), .addr7(addr7),
    .count(count), .div(div), .tx_valid(tx_valid), .tx_byte(tx_byte),
    .tx_take(tx_take), .ev_req(ev_req), .ev_nack(ev_nack),
    .ev_stop(ev_stop), .busy(busy)
  );

  i2c_wr_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .srst(srst), .run(run), .div(div), .tick(tick)
  );

  i2c_wr_engine u_eng (
    .clk(clk), .srst(srst), .tick(tick), .start(start), .addr7(addr7),
    .count(count), .tx_valid(tx_valid), .tx_byte(tx_byte),
    .sda_s(sda_sync_q[SYNC_STAGES-1]), .run(run), .tx_take(tx_take),
    .ev_req(ev_req), .ev_nack(ev_nack), .ev_stop(ev_stop), .busy(busy),
    .scl_oe(scl_oe), .sda_oe(sda_oe)
  );
endmodule

// File: tb/sim_i2c_wr_master.sv
`timescale 1ns/1ps
module sim_i2c_wr_master;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        scl_oe, sda_oe;
  logic        slv_pull = 1'b0;
  wire         scl_bus = ~scl_oe;
  wire         sda_bus = ~(sda_oe | slv_pull);

  int tests = 0, fails = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  i2c_wr_master #(.DIV_RESET(7)) u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sda_in(sda_bus),
    .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  // ---------------- target model ----------------
  logic       addr_ack = 1'b1;
  int         nack_at = -1;
  int         bcnt = 0, nbytes = 0, starts = 0, stops = 0;
  bit         in_xfer = 1'b0;
  logic [7:0] rxs = 8'd0;
  logic [7:0] rxb [16];

  function automatic logic ack_for(input int n);
    return (n == 0) ? addr_ack : ((n - 1) != nack_at);
  endfunction

  always @(negedge sda_bus) if (scl_bus === 1'b1) begin
    starts++; bcnt = -1; in_xfer = 1'b1;
  end
  always @(posedge sda_bus) if (scl_bus === 1'b1) begin
    stops++; in_xfer = 1'b0;
  end
  always @(posedge scl_bus) if (in_xfer && bcnt >= 0 && bcnt < 8)
    rxs = {rxs[6:0], sda_bus};
  always @(negedge scl_bus) if (in_xfer) begin
    bcnt++;
    if (bcnt == 8) begin
      if (nbytes < 16) rxb[nbytes] = rxs;
      slv_pull <= ack_for(nbytes);
    end else if (bcnt == 9) begin
      slv_pull <= 1'b0;
      nbytes++;
      bcnt = 0;
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a;
    @(negedge clk); d = reg_rdata;
  endtask

  function automatic logic [31:0] cmd_word(input logic [6:0] a, input int cnt,
                                            input bit dir, input bit autoe);
    logic [31:0] w = 32'd0;
    w[7:1] = a; w[10] = dir; w[13] = 1'b1; w[23:16] = 8'(cnt); w[25] = autoe;
    return w;
  endfunction

  function automatic logic [31:0] exp_final(input bit refused);
    return refused ? 32'h31 : 32'h21;
  endfunction

  task automatic bus_quiet(input string tag, input int cycles);
    int busy_cycles = 0;
    repeat (cycles) begin
      @(negedge clk);
      if (scl_bus !== 1'b1 || sda_bus !== 1'b1) busy_cycles++;
    end
    chk(tag, busy_cycles, 0);
  endtask

  task automatic xfer(input logic [6:0] a, input int cnt, input logic aack,
                      input int nk, input bit stretch);
    logic [7:0]  d [8];
    logic [31:0] s = 32'd0;
    int reqs = 0, guard = 0, exp_reqs;
    bit dnack;
    string tg;
    for (int i = 0; i < 8; i++) d[i] = 8'($urandom);
    addr_ack = aack; nack_at = nk; nbytes = 0; starts = 0; stops = 0; slv_pull = 1'b0;
    dnack    = aack && nk >= 0 && nk < cnt;
    exp_reqs = !aack ? 0 : (dnack ? nk + 1 : cnt);
    wr(3'd1, cmd_word(a, cnt, 1'b0, 1'b1));
    forever begin
      rd(3'd3, s);
      guard++;
      if (guard > 5000) begin chk("R5 transfer never finished", 0, 1); break; end
      if (s[1]) begin
        chk(reqs == 0 ? "R2 status after address ACK" : "R4 status on next request", s, 32'h8003);
        if (stretch && reqs == 0) begin
          int lows = 0;
          repeat (40) begin @(negedge clk); if (scl_bus === 1'b0) lows++; end
          chk("R9 SCL held low while request pending", lows, 40);
        end
        if (reqs < 8) wr(3'd5, 32'(d[reqs]));
        reqs++;
      end else if (s[5]) break;
    end
    if (!aack)          tg = "R6 final status after refused address";
    else if (dnack)     tg = "R7 final status after refused data";
    else if (cnt == 0)  tg = "R10 final status for zero count";
    else                tg = "R5 final status after last byte";
    chk(tg, s, exp_final(!aack || dnack));
    chk(dnack ? "R7 no request after refusal" : "R4 request count", reqs, exp_reqs);
    chk("R3 address byte MSB first", rxb[0], {a, 1'b0});
    for (int i = 0; i < exp_reqs; i++) chk("R3 data byte MSB first", rxb[i + 1], d[i]);
    chk(aack ? "R3 bytes on bus" : "R6 no data byte on bus", nbytes, 1 + exp_reqs);
    chk("R3 single START", starts, 1);
    chk("R3 single STOP", stops, 1);
    wr(3'd4, 32'h10);
    rd(3'd3, s);
    chk("R8 NACK clear keeps STOP", s, 32'h21);
    wr(3'd4, 32'h20);
    rd(3'd3, s);
    chk("R8 status after clearing", s, 32'h01);
  endtask

  // ---------------- stimulus ----------------
  initial begin
    logic [31:0] s;
    void'($urandom(32'h5EED1234));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    rd(3'd3, s); chk("R1 status after reset", s, 32'h01);
    rd(3'd2, s); chk("R1 divider after reset", s, 32'd7);
    chk("R1 lines released", {30'd0, scl_bus, sda_bus}, 32'd3);

    wr(3'd2, 32'd3);
    wr(3'd0, 32'd1);
    wr(3'd0, 32'd0);
    wr(3'd0, 32'd1);
    rd(3'd2, s); chk("R12 divider kept across enable toggle", s, 32'd3);

    wr(3'd1, cmd_word(7'h44, 2, 1'b1, 1'b1));
    bus_quiet("R11 read direction ignored", 80);
    rd(3'd3, s); chk("R11 busy stays clear (read)", s, 32'h01);
    wr(3'd1, cmd_word(7'h44, 2, 1'b0, 1'b0));
    bus_quiet("R11 no auto-stop ignored", 80);
    rd(3'd3, s); chk("R11 busy stays clear (no auto-stop)", s, 32'h01);

    xfer(7'h44, 2, 1'b1, -1, 1'b1);
    xfer(7'h4C, 2, 1'b0, -1, 1'b0);
    xfer(7'h44, 2, 1'b1, 1, 1'b0);
    xfer(7'h44, 3, 1'b1, 0, 1'b1);
    xfer(7'h7F, 0, 1'b1, -1, 1'b0);
    xfer(7'h00, 1, 1'b1, -1, 1'b0);

    // abort through disable while a request is pending
    addr_ack = 1'b1; nack_at = -1; slv_pull = 1'b0;
    wr(3'd1, cmd_word(7'h2A, 3, 1'b0, 1'b1));
    begin
      int guard = 0;
      do begin rd(3'd3, s); guard++; end while (!s[1] && guard < 2000);
    end
    chk("R2 request before abort", s, 32'h8003);
    wr(3'd0, 32'd0);
    rd(3'd3, s); chk("R12 flags cleared by disable", s, 32'h01);
    bus_quiet("R12 lines released after disable", 40);
    wr(3'd0, 32'd1);
    rd(3'd2, s); chk("R12 divider kept after abort", s, 32'd3);

    for (int n = 0; n < 20; n++) begin
      int cnt = $urandom_range(0, 5);
      int nk  = (cnt > 0 && ($urandom % 3) == 0) ? $urandom_range(0, cnt - 1) : -1;
      xfer(7'($urandom), cnt, ($urandom % 5) != 0, nk, ($urandom % 4) == 0);
    end

    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      tests++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule